// File: doc/BRIEF.md
# Dual-Bank Video Memory Switch

This block sits between two external 16-bit video memory banks and two users: a processor-side memory port and a display read path. At any moment one bank belongs to the host, which reads and writes it, and the other bank belongs to the display. The display address generator supplies an address every cycle, and the pixel word read from the display bank goes on to the palette. Software builds a new picture in the host-side bank, requests a swap, and then rewrites the other bank so that both banks hold the same picture again. Because the display never reads the bank being written, host writes cannot tear the visible image.

A swap request is held until the next start of vertical blanking, so no visible frame mixes the two banks. A two-bit lane mode limits host accesses to the upper byte, the lower byte, or the full word. With byte-only writes, one layer of a two-layer overlay image can be redrawn while the other layer stays as it is. Both returned data paths are registered by default, and a parameter can make them combinational.

Top module: `vram_bank_switch`

## Requirements
- R1: After reset, bank A is the display bank and bank B is the host bank. `disp_bank` and `swap_busy` read 0, `host_rdata` and `disp_pix` read 0, and neither bank write strobe is asserted.
- R2: The host bank always takes `host_addr` and the display bank always takes `disp_addr`. A write strobe is asserted only on the host bank, and only when `host_req` and `host_we` are both high. The two strobes are never high together.
- R3: One clock after an address is presented on `disp_addr`, `disp_pix` shows the word that the display bank held at that address.
- R4: With `lane_mode` 2'b00, a host write drives byte enables 2'b11 and stores all 16 bits of `host_wdata`.
- R5: With `lane_mode` 2'b01 (low byte only), a host write drives byte enables 2'b01 and stores `host_wdata[7:0]` in bits 7:0. Bits 15:8 of the stored word are left unchanged.
- R6: With `lane_mode` 2'b10 (high byte only), a host write drives byte enables 2'b10 and stores `host_wdata[7:0]` in bits 15:8. Bits 7:0 of the stored word are left unchanged.
- R7: One clock after a host read (`host_req` high, `host_we` low), `host_rdata` returns the host-bank word. In mode 2'b00 the whole word is returned. In mode 2'b01 the result is {8'h00, word[7:0]}, and in mode 2'b10 it is {8'h00, word[15:8]}. In all other cycles `host_rdata` holds its value.
- R8: A `swap_req` pulse that does not coincide with `vblank_start` sets `swap_busy` on the next clock. While no `vblank_start` arrives, `disp_bank` does not change.
- R9: When `vblank_start` is high and either `swap_busy` or `swap_req` is high, `disp_bank` toggles at that clock edge and `swap_busy` clears. A `vblank_start` with no request pending leaves `disp_bank` unchanged.
- R10: `lane_mode` 2'b11 behaves exactly like 2'b00 for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host access strobe for this cycle |
| host_we | input | 1 | Host access is a write |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | PIX_W | Host write data (in byte modes the byte is taken from the low lane) |
| lane_mode | input | 2 | 00 full word, 01 low byte, 10 high byte, 11 full word |
| host_rdata | output | PIX_W | Registered host read data, right-aligned in byte modes |
| swap_req | input | 1 | Request to exchange the bank roles |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blanking |
| disp_addr | input | ADDR_W | Display read address |
| disp_pix | output | PIX_W | Registered pixel word from the display bank |
| disp_bank | output | 1 | Bank being displayed (0 = A, 1 = B) |
| swap_busy | output | 1 | A swap is waiting for vertical blanking |
| a_addr | output | ADDR_W | Bank A address |
| a_wdata | output | PIX_W | Bank A write data |
| a_we | output | 1 | Bank A write strobe |
| a_be | output | 2 | Bank A byte enables (bit 1 = upper byte) |
| a_rdata | input | PIX_W | Bank A read data (asynchronous) |
| b_addr | output | ADDR_W | Bank B address |
| b_wdata | output | PIX_W | Bank B write data |
| b_we | output | 1 | Bank B write strobe |
| b_be | output | 2 | Bank B byte enables (bit 1 = upper byte) |
| b_rdata | input | PIX_W | Bank B read data (asynchronous) |

## Verification
Full-word writes over a word with known content check the basic routing. Low-byte and high-byte writes to words whose other byte is already known show whether byte enables and lane placement keep the untouched half, and reads of the same word in all four modes tell right-alignment apart from passing the word through. Host traffic runs at the same time as display fetches, before and after each swap, which shows whether the roles really exchange. Swap requests are placed several cycles ahead of blanking, in the same cycle as blanking, and absent at blanking, which separates latching from immediate switching and from spurious toggles.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

   typedef enum logic [1:0] {
      LANE_FULL     = 2'b00,
      LANE_LOW      = 2'b01,
      LANE_HIGH     = 2'b10,
      LANE_FULL_ALT = 2'b11
   } lane_mode_e;

   localparam int unsigned NUM_BANKS = 2;
   localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/vbs_swap_ctrl.sv
module vbs_swap_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic swap_req,
   input  logic frame_edge,
   output logic disp_sel,
   output logic pending
);

   logic fire;

   assign fire = frame_edge & (pending | swap_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_sel <= 1'b0;
         pending  <= 1'b0;
      end else if (fire) begin
         disp_sel <= ~disp_sel;
         pending  <= 1'b0;
      end else if (swap_req) begin
         pending  <= 1'b1;
      end
   end

endmodule

// File: rtl/vbs_lane_fmt.sv
module vbs_lane_fmt
   import vbs_pkg::*;
#(
   parameter int unsigned PIX_W = 16
) (
   input  lane_mode_e                 mode,
   input  logic [PIX_W-1:0]           host_wdata,
   input  logic [PIX_W-1:0]           bank_rdata,
   output logic [PIX_W-1:0]           wr_data,
   output logic [NUM_LANES-1:0]       wr_be,
   output logic [PIX_W-1:0]           rd_data
);

   localparam int unsigned LANE_W = PIX_W / NUM_LANES;

   logic [LANE_W-1:0] byte_in;
   logic [LANE_W-1:0] lane_lo;
   logic [LANE_W-1:0] lane_hi;

   assign byte_in = host_wdata[LANE_W-1:0];
   assign lane_lo = bank_rdata[LANE_W-1:0];
   assign lane_hi = bank_rdata[PIX_W-1:LANE_W];

   always_comb begin
      unique case (mode)
         LANE_LOW: begin
            wr_be   = 2'b01;
            wr_data = {byte_in, byte_in};
            rd_data = {{LANE_W{1'b0}}, lane_lo};
         end
         LANE_HIGH: begin
            wr_be   = 2'b10;
            wr_data = {byte_in, byte_in};
            rd_data = {{LANE_W{1'b0}}, lane_hi};
         end
         default: begin
            wr_be   = 2'b11;
            wr_data = host_wdata;
            rd_data = bank_rdata;
         end
      endcase
   end

endmodule

// File: rtl/vbs_bank_port.sv
module vbs_bank_port
   import vbs_pkg::*;
#(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned PIX_W  = 16
) (
   input  logic                   is_host,
   input  logic                   host_req,
   input  logic                   host_we,
   input  logic [ADDR_W-1:0]      host_addr,
   input  logic [PIX_W-1:0]       wr_data,
   input  logic [NUM_LANES-1:0]   wr_be,
   input  logic [ADDR_W-1:0]      disp_addr,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [PIX_W-1:0]       mem_wdata,
   output logic                   mem_we,
   output logic [NUM_LANES-1:0]   mem_be
);

   logic wr_now;

   assign wr_now    = is_host & host_req & host_we;
   assign mem_addr  = is_host ? host_addr : disp_addr;
   assign mem_wdata = is_host ? wr_data : '0;
   assign mem_we    = wr_now;
   assign mem_be    = wr_now ? wr_be : '0;

endmodule

// File: rtl/vbs_read_stage.sv
module vbs_read_stage #(
   parameter int unsigned W       = 16,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q <= '0;
         else if (load) q <= d;
      end
   end else begin : g_comb
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ load;
      assign q = d;
   end

endmodule

// File: rtl/vram_bank_switch.sv
module vram_bank_switch
   import vbs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 20,
   parameter int unsigned PIX_W   = 16,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [PIX_W-1:0]  host_wdata,
   input  logic [1:0]        lane_mode,
   output logic [PIX_W-1:0]  host_rdata,
   input  logic              swap_req,
   input  logic              vblank_start,
   input  logic [ADDR_W-1:0] disp_addr,
   output logic [PIX_W-1:0]  disp_pix,
   output logic              disp_bank,
   output logic              swap_busy,
   output logic [ADDR_W-1:0] a_addr,
   output logic [PIX_W-1:0]  a_wdata,
   output logic              a_we,
   output logic [1:0]        a_be,
   input  logic [PIX_W-1:0]  a_rdata,
   output logic [ADDR_W-1:0] b_addr,
   output logic [PIX_W-1:0]  b_wdata,
   output logic              b_we,
   output logic [1:0]        b_be,
   input  logic [PIX_W-1:0]  b_rdata
);

   if (PIX_W < 2 || (PIX_W % NUM_LANES) != 0) begin : g_bad_pix
      $error("PIX_W must be an even width of at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr
      $error("ADDR_W out of range");
   end

   lane_mode_e                 mode;
   logic                       disp_sel;
   logic [PIX_W-1:0]           wr_data;
   logic [NUM_LANES-1:0]       wr_be;
   logic [PIX_W-1:0]           host_raw;
   logic [PIX_W-1:0]           host_fmt;
   logic [PIX_W-1:0]           disp_raw;

   logic [ADDR_W-1:0]          bk_addr  [NUM_BANKS];
   logic [PIX_W-1:0]           bk_wdata [NUM_BANKS];
   logic                       bk_we    [NUM_BANKS];
   logic [NUM_LANES-1:0]       bk_be    [NUM_BANKS];
   logic [PIX_W-1:0]           bk_rdata [NUM_BANKS];

   assign mode = lane_mode_e'(lane_mode);

   vbs_swap_ctrl u_swap (
      .clk        (clk),
      .rst_n      (rst_n),
      .swap_req   (swap_req),
      .frame_edge (vblank_start),
      .disp_sel   (disp_sel),
      .pending    (swap_busy)
   );

   assign disp_bank = disp_sel;

   assign bk_rdata[0] = a_rdata;
   assign bk_rdata[1] = b_rdata;
   assign host_raw    = bk_rdata[~disp_sel];
   assign disp_raw    = bk_rdata[disp_sel];

   vbs_lane_fmt #(.PIX_W(PIX_W)) u_fmt (
      .mode       (mode),
      .host_wdata (host_wdata),
      .bank_rdata (host_raw),
      .wr_data    (wr_data),
      .wr_be      (wr_be),
      .rd_data    (host_fmt)
   );

   for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      vbs_bank_port #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_port (
         .is_host   (disp_sel != 1'(gb)),
         .host_req  (host_req),
         .host_we   (host_we),
         .host_addr (host_addr),
         .wr_data   (wr_data),
         .wr_be     (wr_be),
         .disp_addr (disp_addr),
         .mem_addr  (bk_addr[gb]),
         .mem_wdata (bk_wdata[gb]),
         .mem_we    (bk_we[gb]),
         .mem_be    (bk_be[gb])
      );
   end

   assign a_addr  = bk_addr[0];
   assign a_wdata = bk_wdata[0];
   assign a_we    = bk_we[0];
   assign a_be    = bk_be[0];
   assign b_addr  = bk_addr[1];
   assign b_wdata = bk_wdata[1];
   assign b_we    = bk_we[1];
   assign b_be    = bk_be[1];

   vbs_read_stage #(.W(PIX_W), .OUT_REG(OUT_REG)) u_host_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (host_req & ~host_we),
      .d     (host_fmt),
      .q     (host_rdata)
   );

   vbs_read_stage #(.W(PIX_W), .OUT_REG(OUT_REG)) u_disp_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (1'b1),
      .d     (disp_raw),
      .q     (disp_pix)
   );

endmodule

// File: rtl/vbs_checker.sv
module vbs_checker #(
   parameter int unsigned ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_req,
   input logic              host_we,
   input logic [1:0]        lane_mode,
   input logic              swap_req,
   input logic              vblank_start,
   input logic [ADDR_W-1:0] disp_addr,
   input logic [ADDR_W-1:0] a_addr,
   input logic              a_we,
   input logic [1:0]        a_be,
   input logic [ADDR_W-1:0] b_addr,
   input logic              b_we,
   input logic [1:0]        b_be,
   input logic              disp_bank,
   input logic              swap_busy
);

   // R2
   we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_we && b_we));

   // R2
   disp_a_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_bank == 1'b0) |-> (a_addr == disp_addr && !a_we));

   // R2
   disp_b_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_bank == 1'b1) |-> (b_addr == disp_addr && !b_we));

   // R2
   we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_we || b_we) |-> (host_req && host_we));

   // R5
   low_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((a_we || b_we) && lane_mode == 2'b01) |-> ((a_we ? a_be : b_be) == 2'b01));

   // R6
   high_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((a_we || b_we) && lane_mode == 2'b10) |-> ((a_we ? a_be : b_be) == 2'b10));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vblank_start |=> $stable(disp_bank));

   // R8
   pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (swap_req && !vblank_start) |=> swap_busy);

   // R9
   swap_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vblank_start && (swap_busy || swap_req)) |=> (disp_bank != $past(disp_bank) && !swap_busy));

endmodule

bind vram_bank_switch vbs_checker #(.ADDR_W(ADDR_W)) u_vbs_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_req     (host_req),
   .host_we      (host_we),
   .lane_mode    (lane_mode),
   .swap_req     (swap_req),
   .vblank_start (vblank_start),
   .disp_addr    (disp_addr),
   .a_addr       (a_addr),
   .a_we         (a_we),
   .a_be         (a_be),
   .b_addr       (b_addr),
   .b_we         (b_we),
   .b_be         (b_be),
   .disp_bank    (disp_bank),
   .swap_busy    (swap_busy)
);

// File: tb/vram_bank_switch_tb_top.sv
`timescale 1ns/1ps
module vram_bank_switch_tb_top;

   localparam int AW = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_req = 1'b0, host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [15:0]   host_wdata = '0;
   logic [1:0]    lane_mode = 2'b00;
   logic [15:0]   host_rdata;
   logic          swap_req = 1'b0, vblank_start = 1'b0;
   logic [AW-1:0] disp_addr = '0;
   logic [15:0]   disp_pix;
   logic          disp_bank, swap_busy;
   logic [AW-1:0] a_addr, b_addr;
   logic [15:0]   a_wdata, b_wdata, a_rdata, b_rdata;
   logic          a_we, b_we;
   logic [1:0]    a_be, b_be;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   vram_bank_switch #(.ADDR_W(AW), .PIX_W(16)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .lane_mode(lane_mode), .host_rdata(host_rdata),
      .swap_req(swap_req), .vblank_start(vblank_start),
      .disp_addr(disp_addr), .disp_pix(disp_pix),
      .disp_bank(disp_bank), .swap_busy(swap_busy),
      .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_be(a_be), .a_rdata(a_rdata),
      .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_be(b_be), .b_rdata(b_rdata)
   );

   // external bank devices
   logic [15:0] mem_a [DEPTH];
   logic [15:0] mem_b [DEPTH];
   assign a_rdata = mem_a[a_addr];
   assign b_rdata = mem_b[b_addr];

   always @(posedge clk) begin
      if (a_we) begin
         if (a_be[0]) mem_a[a_addr][7:0]  <= a_wdata[7:0];
         if (a_be[1]) mem_a[a_addr][15:8] <= a_wdata[15:8];
      end
      if (b_we) begin
         if (b_be[0]) mem_b[b_addr][7:0]  <= b_wdata[7:0];
         if (b_be[1]) mem_b[b_addr][15:8] <= b_wdata[15:8];
      end
   end

   // reference model state
   logic [15:0] ref_mem [2][DEPTH];
   int          m_disp = 0;
   bit          m_busy = 0;
   logic [15:0] exp_hrd = '0;
   logic [15:0] exp_pix = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] shape_read(input logic [15:0] w, input logic [1:0] md);
      if (md == 2'b01) return {8'h00, w[7:0]};
      if (md == 2'b10) return {8'h00, w[15:8]};
      return w;
   endfunction

   task automatic cyc(input logic req, input logic we, input logic [AW-1:0] ad,
                      input logic [15:0] wd, input logic [1:0] md,
                      input logic sw, input logic vb, input logic [AW-1:0] da,
                      input string tag);
      int hb;
      logic [1:0] be_exp;
      host_req = req; host_we = we; host_addr = ad; host_wdata = wd;
      lane_mode = md; swap_req = sw; vblank_start = vb; disp_addr = da;
      #1;
      hb = 1 - m_disp;
      be_exp = (md == 2'b01) ? 2'b01 : (md == 2'b10) ? 2'b10 : 2'b11;
      // R2: routing and strobes
      chk({tag, " R2 a_we"}, a_we, (req && we && hb == 0));
      chk({tag, " R2 b_we"}, b_we, (req && we && hb == 1));
      chk({tag, " R2 a_addr"}, a_addr, (hb == 0) ? ad : da);
      chk({tag, " R2 b_addr"}, b_addr, (hb == 1) ? ad : da);
      if (req && we)
         chk({tag, " byte enables"}, (hb == 0) ? a_be : b_be, be_exp);
      @(posedge clk);
      exp_pix = ref_mem[m_disp][da];
      if (req && !we) exp_hrd = shape_read(ref_mem[hb][ad], md);
      if (req && we) begin
         if (md == 2'b01)      ref_mem[hb][ad][7:0]  = wd[7:0];
         else if (md == 2'b10) ref_mem[hb][ad][15:8] = wd[7:0];
         else                  ref_mem[hb][ad]       = wd;
      end
      if (vb && (m_busy || sw)) begin
         m_disp = 1 - m_disp;
         m_busy = 0;
      end else if (sw) begin
         m_busy = 1;
      end
      @(negedge clk);
      chk({tag, " R3 disp_pix"}, disp_pix, exp_pix);
      chk({tag, " R7 host_rdata"}, host_rdata, exp_hrd);
      chk({tag, " R9 disp_bank"}, disp_bank, m_disp[0]);
      chk({tag, " R8 swap_busy"}, swap_busy, m_busy);
   endtask

   task automatic rd(input logic [AW-1:0] ad, input logic [1:0] md, input string tag);
      cyc(1, 0, ad, 16'h0, md, 0, 0, ad + 8'd1, tag);
   endtask

   task automatic wr(input logic [AW-1:0] ad, input logic [15:0] wd, input logic [1:0] md, input string tag);
      cyc(1, 1, ad, wd, md, 0, 0, ad + 8'd2, tag);
   endtask

   task automatic idle(input logic sw, input logic vb, input string tag);
      cyc(0, 0, 8'd0, 16'h0, 2'b00, sw, vb, 8'd9, tag);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         mem_a[i] = 16'hA000 + 16'(i);
         mem_b[i] = 16'hB000 + 16'(i);
         ref_mem[0][i] = 16'hA000 + 16'(i);
         ref_mem[1][i] = 16'hB000 + 16'(i);
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 disp_bank", disp_bank, 0);
      chk("R1 swap_busy", swap_busy, 0);
      chk("R1 host_rdata", host_rdata, 0);
      chk("R1 disp_pix", disp_pix, 0);
      chk("R1 a_we", a_we, 0);
      chk("R1 b_we", b_we, 0);
      rst_n = 1'b1;

      // R3: display fetches from bank A
      for (int k = 0; k < 4; k++)
         cyc(0, 0, 8'd0, 16'h0, 2'b00, 0, 0, 8'(k * 7), "R3 fetch");

      // R4: full write to host bank B, read back
      wr(8'd5, 16'h1234, 2'b00, "R4 full write");
      rd(8'd5, 2'b00, "R4 full readback");

      // R5: low byte write keeps upper byte
      wr(8'd6, 16'h77CD, 2'b01, "R5 low write");
      rd(8'd6, 2'b00, "R5 word after low write");
      rd(8'd6, 2'b01, "R7 low read");
      rd(8'd6, 2'b10, "R7 high read");

      // R6: high byte write keeps lower byte
      wr(8'd7, 16'h5512, 2'b10, "R6 high write");
      rd(8'd7, 2'b00, "R6 word after high write");

      // R10: mode 3 acts as full word
      wr(8'd8, 16'hBEEF, 2'b11, "R10 write");
      rd(8'd8, 2'b11, "R10 read");

      // R7: hold when no read
      idle(0, 0, "R7 hold");

      // R8: request latched, no switch without blanking
      idle(1, 0, "R8 request");
      idle(0, 0, "R8 wait");
      wr(8'd3, 16'h0F0F, 2'b00, "R8 write while pending");
      idle(0, 0, "R8 wait2");

      // R9: blanking performs the swap
      idle(0, 1, "R9 swap");
      cyc(0, 0, 8'd0, 16'h0, 2'b00, 0, 0, 8'd5, "R9 display B word 5");
      cyc(0, 0, 8'd0, 16'h0, 2'b00, 0, 0, 8'd6, "R9 display B word 6");
      // host now on bank A
      wr(8'd5, 16'h1234, 2'b00, "R2 rewrite A");
      rd(8'd5, 2'b00, "R2 read A");
      wr(8'd6, 16'h00AB, 2'b10, "R6 write A high");
      rd(8'd6, 2'b00, "R6 read A");

      // R9: blanking without request keeps banks
      idle(0, 1, "R9 no request");
      idle(0, 0, "R9 steady");

      // R9: request and blanking together
      idle(1, 1, "R9 same cycle");
      cyc(0, 0, 8'd0, 16'h0, 2'b00, 0, 0, 8'd5, "R3 display A word 5");
      rd(8'd7, 2'b01, "R7 low read B");

      // concurrent host and display traffic
      for (int k = 0; k < 6; k++)
         cyc(1, k[0], 8'(20 + k), 16'(16'h3300 + k), 2'(k % 3), 0, 0, 8'(40 + k), "R2 mixed");
      for (int k = 0; k < 6; k++)
         rd(8'(20 + k), 2'b00, "R4 mixed readback");

      finish_run();
   end

endmodule